// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block sends a host-paced, multi-byte in-frame response on a single-wire serial bus where a logic zero is dominant. The host loads one byte into a holding register and sets a request flag. The block then sends a normalization symbol. After that it moves the held byte into a shift register and sends it one bit at a time, most significant bit first. Each time a byte moves into the shift register, a data-empty flag rises so that the host can supply the next byte.

When the host requests end of data, the block finishes the byte in flight and any byte still held. It then appends an inverted CRC-8 byte and an end-of-data symbol, and returns to idle. The physical layer is modelled as a per-symbol valid/ready handshake. The bus level seen during each accepted bit is returned on `rx_bit`. If the block drives a recessive one and sees a dominant zero, it abandons the response and raises a loss flag. If that happens on the last bit of a byte, the block first sends two extra one bits to force a byte-boundary fault. A request that arrives in a short window after an end-of-data symbol is received from the bus is ignored.

Top module: `ifr_tx_seq`

## Requirements
- R1: After synchronous reset, `sym_valid`, `req_flag`, `tdre` and `lost_flag` are 0 and the holding register is empty.
- R2: With `req_flag` set, a byte held and the block idle, the block first offers a normalization symbol (`sym_kind` 0, `sym_bit` 0). It then offers the held byte as DW bit symbols (`sym_kind` 1), most significant bit first. A symbol stays unchanged while `sym_ready` is low.
- R3: `tdre` rises in the cycle after a held byte moves into the shift register, which happens on acceptance of the normalization symbol or at a byte boundary. It falls on `data_wr`, on `eod_set`, or at the end of the response.
- R4: An `eod_set` pulse while `req_flag` is 1 makes the block finish the current byte and any byte still held, then send the CRC byte, then an end-of-data symbol (`sym_kind` 2, `sym_bit` 0). The cycle after that symbol is accepted, `req_flag` is 0 and the block is idle.
- R5: If the only byte was loaded before the request and `eod_set` arrives at the first `tdre`, that byte is the only data byte before the CRC, and `tdre` does not rise again.
- R6: A `req_set` in the cycle of an `rx_eod` pulse, or in the IGNORE_CYC cycles after it, is ignored: `req_flag` stays 0 and nothing is sent.
- R7: If a bit symbol driving 1 is accepted while `rx_bit` is 0, the following happens in the next cycle: `lost_flag` is 1, `req_flag`, `tdre` and the pending end request are cleared, and no further data symbol of that response is sent.
- R8: If that loss happens on the last bit of a byte, the block sends exactly two more bit symbols with `sym_bit` 1 and then goes idle.
- R9: A `lost_clr` pulse clears `lost_flag` in the next cycle, unless a new loss is detected in the same cycle.
- R10: At a byte boundary where no byte is held and no end request is pending, `sym_valid` stays 0 until a byte is written.
- R11: The CRC is CRC-8 with polynomial 0x1D, preset to 0xFF and run over the data bits MSB first. It is sent inverted, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | DW | Byte written to the holding register |
| data_wr | input | 1 | Write pulse for the holding register |
| req_set | input | 1 | Host pulse that sets the response request flag |
| eod_set | input | 1 | Host pulse requesting CRC and end of data |
| lost_clr | input | 1 | Write-one-to-clear pulse for the loss flag |
| rx_eod | input | 1 | Pulse: end-of-data symbol received from the bus |
| sym_ready | input | 1 | Physical layer accepts the offered symbol |
| rx_bit | input | 1 | Bus level sampled during the accepted symbol |
| sym_valid | output | 1 | A symbol is offered |
| sym_kind | output | 2 | 0 normalization, 1 data bit, 2 end of data |
| sym_bit | output | 1 | Bit value for data-bit symbols |
| req_flag | output | 1 | Response request flag |
| tdre | output | 1 | Holding register empty, next byte wanted |
| lost_flag | output | 1 | Arbitration was lost |

## Verification
A wrong state, bit counter or shift register shows up at the symbol port within one accepted symbol. It appears as a missing normalization prefix, a bit out of order, a CRC byte that differs from the value computed in the bench, or a trailer that comes too early or too late. Faulty flag logic shows in the cycle after the triggering handshake or host pulse. Examples are an extra `tdre` rise after the end request, a loss flag that misses a forced zero, or a request accepted inside the ignore window. A fault in the loss path also shows up one symbol later, as symbols that continue after the loss or padding bits that are missing.

// File: rtl/ifr_pkg.sv
`timescale 1ns/1ps
package ifr_pkg;
    typedef enum logic [1:0] {
        SYM_NORM = 2'd0,
        SYM_BIT  = 2'd1,
        SYM_EOD  = 2'd2
    } sym_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_DATA,
        ST_BOUND,
        ST_CRC,
        ST_EOD,
        ST_PAD
    } seq_st_e;
endpackage

// File: rtl/ifr_crc_step.sv
`timescale 1ns/1ps
module ifr_crc_step #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h1D
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    output logic [W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[W-1] ^ bit_in;
        crc_out = {crc_in[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/ifr_arb_det.sv
`timescale 1ns/1ps
module ifr_arb_det (
    input  logic accept,
    input  logic is_bit,
    input  logic drove,
    input  logic seen,
    output logic lost
);
    // recessive one driven, dominant zero observed
    always_comb lost = accept && is_bit && drove && !seen;
endmodule

// File: rtl/ifr_ign_win.sv
`timescale 1ns/1ps
module ifr_ign_win #(
    parameter int IGN_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic eod_seen,
    output logic blocked
);
    localparam int CW = $clog2(IGN_CYC + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (eod_seen)
            cnt_d = CW'(IGN_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        blocked = eod_seen || (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ifr_tx_seq.sv
`timescale 1ns/1ps
module ifr_tx_seq #(
    parameter int            DW       = 8,
    parameter int            IGN_CYC  = 2,
    parameter logic [DW-1:0] CRC_POLY = 8'h1D,
    parameter logic [DW-1:0] CRC_INIT = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] data_in,
    input  logic          data_wr,
    input  logic          req_set,
    input  logic          eod_set,
    input  logic          lost_clr,
    input  logic          rx_eod,
    input  logic          sym_ready,
    input  logic          rx_bit,
    output logic          sym_valid,
    output logic [1:0]    sym_kind,
    output logic          sym_bit,
    output logic          req_flag,
    output logic          tdre,
    output logic          lost_flag
);
    import ifr_pkg::*;

    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [DW-1:0] hold;
        logic          hold_full;
        logic [DW-1:0] shreg;
        logic [CW-1:0] cnt;
        logic [DW-1:0] crc;
        logic          req;
        logic          eod;
        logic          tdre;
        logic          lost;
    } seq_state_t;

    seq_state_t    q, d;
    logic          accept;
    logic          blocked;
    logic          arb_lost;
    logic [DW-1:0] crc_nx;

    ifr_ign_win #(.IGN_CYC(IGN_CYC)) u_win (
        .clk      (clk),
        .rst      (rst),
        .eod_seen (rx_eod),
        .blocked  (blocked)
    );

    ifr_crc_step #(.W(DW), .POLY(CRC_POLY)) u_crc (
        .crc_in  (q.crc),
        .bit_in  (q.shreg[DW-1]),
        .crc_out (crc_nx)
    );

    ifr_arb_det u_arb (
        .accept (accept),
        .is_bit (sym_kind == SYM_BIT),
        .drove  (sym_bit),
        .seen   (rx_bit),
        .lost   (arb_lost)
    );

    // symbol offer derived from the registered state only
    always_comb begin
        sym_valid = 1'b0;
        sym_kind  = SYM_BIT;
        sym_bit   = 1'b0;
        unique case (q.st)
            ST_NORM: begin sym_valid = 1'b1; sym_kind = SYM_NORM; end
            ST_EOD:  begin sym_valid = 1'b1; sym_kind = SYM_EOD;  end
            ST_DATA, ST_CRC: begin
                sym_valid = 1'b1;
                sym_bit   = q.shreg[DW-1];
            end
            ST_PAD:  begin sym_valid = 1'b1; sym_bit = 1'b1; end
            default: ;
        endcase
        accept = sym_valid && sym_ready;
    end

    always_comb begin
        d = q;

        // host side
        if (data_wr) begin
            d.hold      = data_in;
            d.hold_full = 1'b1;
            d.tdre      = 1'b0;
        end
        if (eod_set && q.req) begin
            d.eod  = 1'b1;
            d.tdre = 1'b0;
        end
        if (req_set && !blocked)
            d.req = 1'b1;
        if (lost_clr)
            d.lost = 1'b0;

        // sequencing
        unique case (q.st)
            ST_IDLE: begin
                if (q.req && q.hold_full && !blocked) begin
                    d.st  = ST_NORM;
                    d.crc = CRC_INIT;
                end
            end
            ST_NORM: begin
                if (accept) begin
                    d.shreg     = q.hold;
                    d.hold_full = data_wr;
                    d.tdre      = !data_wr && !d.eod;
                    d.cnt       = LAST_IDX;
                    d.st        = ST_DATA;
                end
            end
            ST_DATA, ST_CRC: begin
                if (accept) begin
                    if (arb_lost) begin
                        d.lost = 1'b1;
                        d.req  = 1'b0;
                        d.tdre = 1'b0;
                        d.eod  = 1'b0;
                        if (q.cnt == '0) begin
                            d.st  = ST_PAD;
                            d.cnt = CW'(1);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        if (q.st == ST_DATA)
                            d.crc = crc_nx;
                        d.shreg = {q.shreg[DW-2:0], 1'b0};
                        if (q.cnt == '0)
                            d.st = (q.st == ST_DATA) ? ST_BOUND : ST_EOD;
                        else
                            d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_BOUND: begin
                if (q.hold_full) begin
                    d.shreg     = q.hold;
                    d.hold_full = data_wr;
                    d.tdre      = !data_wr && !d.eod;
                    d.cnt       = LAST_IDX;
                    d.st        = ST_DATA;
                end else if (q.eod) begin
                    d.shreg = ~q.crc;
                    d.cnt   = LAST_IDX;
                    d.st    = ST_CRC;
                end
            end
            ST_EOD: begin
                if (accept) begin
                    d.st   = ST_IDLE;
                    d.req  = 1'b0;
                    d.eod  = 1'b0;
                    d.tdre = 1'b0;
                end
            end
            ST_PAD: begin
                if (accept) begin
                    if (q.cnt == '0) d.st = ST_IDLE;
                    else             d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st        <= ST_IDLE;
            q.hold      <= '0;
            q.hold_full <= 1'b0;
            q.shreg     <= '0;
            q.cnt       <= '0;
            q.crc       <= CRC_INIT;
            q.req       <= 1'b0;
            q.eod       <= 1'b0;
            q.tdre      <= 1'b0;
            q.lost      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_flag  = q.req;
    assign tdre      = q.tdre;
    assign lost_flag = q.lost;
endmodule

// File: rtl/ifr_tx_seq_chk.sv
`timescale 1ns/1ps
module ifr_tx_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_set,
    input logic       data_wr,
    input logic       lost_clr,
    input logic       rx_eod,
    input logic       sym_ready,
    input logic       rx_bit,
    input logic       sym_valid,
    input logic [1:0] sym_kind,
    input logic       sym_bit,
    input logic       req_flag,
    input logic       tdre,
    input logic       lost_flag
);
    logic loss_ev;
    assign loss_ev = sym_valid && sym_ready && (sym_kind == 2'd1) && sym_bit && !rx_bit;

    // R2
    sym_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_kind) && $stable(sym_bit)));

    // R3
    tdre_wr_chk: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> !tdre);

    // R4
    eod_end_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && sym_kind == 2'd2) |=> (!req_flag && !sym_valid));

    // R6
    ign_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_eod && req_set && !req_flag) |=> !req_flag);

    // R7
    lost_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_flag) |-> $past(loss_ev));

    // R7
    lost_stop_chk: assert property (@(posedge clk) disable iff (rst)
        loss_ev |=> (!req_flag && !tdre && lost_flag));

    // R9
    lost_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (lost_clr && !loss_ev) |=> !lost_flag);
endmodule

bind ifr_tx_seq ifr_tx_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_set   (req_set),
    .data_wr   (data_wr),
    .lost_clr  (lost_clr),
    .rx_eod    (rx_eod),
    .sym_ready (sym_ready),
    .rx_bit    (rx_bit),
    .sym_valid (sym_valid),
    .sym_kind  (sym_kind),
    .sym_bit   (sym_bit),
    .req_flag  (req_flag),
    .tdre      (tdre),
    .lost_flag (lost_flag)
);

// File: tb/tb_ifr_tx_seq.sv
`timescale 1ns/1ps
module tb_ifr_tx_seq;
    localparam int IGN = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] data_in = '0;
    logic       data_wr = 1'b0, req_set = 1'b0, eod_set = 1'b0, lost_clr = 1'b0;
    logic       rx_eod = 1'b0, sym_ready = 1'b0, rx_bit = 1'b1;
    logic       sym_valid, sym_bit, req_flag, tdre, lost_flag;
    logic [1:0] sym_kind;

    ifr_tx_seq #(.DW(8), .IGN_CYC(IGN)) dut (
        .clk(clk), .rst(rst), .data_in(data_in), .data_wr(data_wr),
        .req_set(req_set), .eod_set(eod_set), .lost_clr(lost_clr),
        .rx_eod(rx_eod), .sym_ready(sym_ready), .rx_bit(rx_bit),
        .sym_valid(sym_valid), .sym_kind(sym_kind), .sym_bit(sym_bit),
        .req_flag(req_flag), .tdre(tdre), .lost_flag(lost_flag)
    );

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [2:0] log_q [0:127];
    int  log_n = 0, lose_at = -1, tdre_rises = 0;
    bit  stall_rdy = 0;
    logic tdre_prev = 1'b0;

    // bus model: accepts symbols, echoes or forces the bus level
    always @(negedge clk) begin
        cyc++;
        if (tdre && !tdre_prev) tdre_rises++;
        tdre_prev = tdre;
        if (!rst && sym_valid && (!stall_rdy || (cyc % 2 == 0))) begin
            sym_ready = 1'b1;
            rx_bit    = (log_n == lose_at) ? 1'b0 : sym_bit;
            if (log_n < 128) log_q[log_n] = {sym_kind, sym_bit};
            log_n++;
        end else begin
            sym_ready = 1'b0;
            rx_bit    = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_tdre();
        int w = 0;
        @(negedge clk);
        while (!tdre && w < 500) begin @(negedge clk); w++; end
    endtask

    function automatic logic [7:0] crc_of(input logic [7:0] b [0:7], input int n);
        logic [7:0] c = 8'hFF;
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) begin
                logic fb = c[7] ^ b[k][i];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
            end
        return ~c;
    endfunction

    task automatic run_frame(input int n, input bit var_b, input bit gap, input int seed);
        logic [7:0] b [0:7];
        logic [2:0] e [0:127];
        logic [7:0] crc;
        int en = 0, w = 0, bad_at = -1, exp_r;
        for (int k = 0; k < 8; k++) b[k] = 8'((seed * 37 + k * 91 + 5) & 255);
        log_n = 0; tdre_rises = 0; lose_at = -1;
        @(negedge clk);
        data_in = b[0]; data_wr = 1'b1; req_set = 1'b1;
        @(negedge clk);
        data_wr = 1'b0; req_set = 1'b0;
        for (int k = 1; k < n; k++) begin
            wait_tdre();
            if (gap && k == 1) begin
                repeat (30) @(negedge clk);
                check(sym_valid == 1'b0, "R10 stall at empty boundary", int'(sym_valid), 0);
                check(log_n == 9, "R10 symbols before stall", log_n, 9);
            end
            data_in = b[k]; data_wr = 1'b1;
            if (var_b && k == n - 1) eod_set = 1'b1;
            @(negedge clk);
            data_wr = 1'b0; eod_set = 1'b0;
        end
        if (!var_b || n == 1) begin
            wait_tdre();
            eod_set = 1'b1;
            @(negedge clk);
            eod_set = 1'b0;
        end
        while ((req_flag || sym_valid) && w < 2000) begin @(negedge clk); w++; end
        // expected stream
        e[en++] = {2'd0, 1'b0};
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) e[en++] = {2'd1, b[k][i]};
        crc = crc_of(b, n);
        for (int i = 7; i >= 0; i--) e[en++] = {2'd1, crc[i]};
        e[en++] = {2'd2, 1'b0};
        check(log_n == en, "R4 symbol count", log_n, en);
        for (int i = 0; i < en && i < log_n; i++)
            if (bad_at < 0 && log_q[i] !== e[i]) bad_at = i;
        check(bad_at < 0, "R11 R2 symbol stream (index of first diff)", bad_at, -1);
        exp_r = (var_b && n >= 2) ? n - 1 : n;
        if (n == 1) check(tdre_rises == 1, "R5 single byte empty rises", tdre_rises, 1);
        else        check(tdre_rises == exp_r, "R3 empty rises", tdre_rises, exp_r);
        check(!req_flag && !tdre, "R4 idle after trailer", int'({req_flag, tdre}), 0);
    endtask

    task automatic loss_case(input int p);
        int exp_n = (p < 8) ? p + 1 : 11;
        log_n = 0; lose_at = p;
        @(negedge clk);
        data_in = 8'hFF; data_wr = 1'b1; req_set = 1'b1;
        @(negedge clk);
        data_wr = 1'b0; req_set = 1'b0;
        repeat (40) @(negedge clk);
        lose_at = -1;
        if (p < 8) check(log_n == exp_n, "R7 no symbols after loss", log_n, exp_n);
        else begin
            check(log_n == exp_n, "R8 padding count", log_n, exp_n);
            check(log_q[9] == 3'b011 && log_q[10] == 3'b011, "R8 padding ones",
                  int'({log_q[9], log_q[10]}), 27);
        end
        check(lost_flag == 1'b1, "R7 loss flag", int'(lost_flag), 1);
        check(!req_flag && !tdre && !sym_valid, "R7 request cleared",
              int'({req_flag, tdre, sym_valid}), 0);
        lost_clr = 1'b1;
        @(negedge clk);
        lost_clr = 1'b0;
        check(lost_flag == 1'b0, "R9 loss flag cleared", int'(lost_flag), 0);
    endtask

    initial begin
        do_reset();
        check(sym_valid == 0, "R1 sym_valid", int'(sym_valid), 0);
        check(req_flag == 0,  "R1 req_flag", int'(req_flag), 0);
        check(tdre == 0,      "R1 tdre", int'(tdre), 0);
        check(lost_flag == 0, "R1 lost_flag", int'(lost_flag), 0);

        // ignore window sweep
        for (int dly = 0; dly <= IGN + 1; dly++) begin
            do_reset();
            rx_eod = 1'b1;
            if (dly == 0) req_set = 1'b1;
            @(negedge clk);
            rx_eod = 1'b0; req_set = 1'b0;
            if (dly > 0) begin
                repeat (dly - 1) @(negedge clk);
                req_set = 1'b1;
                @(negedge clk);
                req_set = 1'b0;
            end
            check(req_flag == (dly > IGN), "R6 request after rx eod",
                  int'(req_flag), int'(dly > IGN));
            check(sym_valid == 0, "R6 nothing sent", int'(sym_valid), 0);
        end

        do_reset();
        for (int n = 1; n <= 4; n++) begin
            run_frame(n, 1'b0, 1'b0, n);
            if (n >= 2) run_frame(n, 1'b1, 1'b0, n + 11);
        end
        run_frame(2, 1'b0, 1'b1, 7);
        stall_rdy = 1;
        run_frame(3, 1'b0, 1'b0, 23);
        stall_rdy = 0;

        for (int p = 1; p <= 8; p++) loss_case(p);
        run_frame(2, 1'b1, 1'b0, 42);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule